// File: doc/BRIEF.md
# Register-Mapped GPIO Bank with Hardware Blink

This block is one bank of general-purpose I/O lines. The number of lines is set by a parameter, up to 32. A small byte-addressed register bus controls it: a write strobe and a read strobe, an address, and 32-bit write and read data. Software sets four things for each line: the static output level, the direction, whether the line blinks, and whether its input is inverted. Software also reads back the pins after synchronisation.

On the pad side the block drives an output-value vector and an output-enable vector, and it samples the raw pin vector through a two-flop synchroniser. A free-running divider produces a single square-wave phase. Every line whose blink bit is set drives that phase instead of its static output bit, so all blinking lines change together.

Top module: `gpio_blink_port`

## Requirements
- R1: After reset, the output, blink and polarity registers read 0. The direction register reads 1 on every implemented line. As a result pad_oe is all zero and pad_out is all zero.
- R2: The direction register sits at offset 0x04. A bit value of 1 makes the line an input (pad_oe bit low). A bit value of 0 makes it an output (pad_oe bit high).
- R3: The output register sits at offset 0x00. Each line that is not blinking drives its bit of this register on pad_out, whatever its direction.
- R4: A read of offset 0x10 returns the synchronised pin level XORed with the polarity register at offset 0x0C. A pin change is visible to a read issued on the third clock after the change.
- R5: The blink register sits at offset 0x08. A line with its bit set drives the shared blink phase on pad_out, and that phase toggles every BLINK_HALF clocks. All blinking lines carry the same value in the same cycle.
- R6: Writes to offset 0x10 change no register.
- R7: Reads of any offset other than 0x00, 0x04, 0x08, 0x0C and 0x10 return zero. Writes to those offsets change no register.
- R8: Bits at positions LINES and above always read as zero, and writes to them are dropped.
- R9: rdata is valid in the cycle after rd_en is sampled high. In any cycle that follows a cycle without rd_en, rdata is zero.
- R10: A value written to offset 0x00, 0x04, 0x08 or 0x0C reads back unchanged within the implemented lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| pin_in | input | LINES | Raw pin levels |
| pad_out | output | LINES | Pad output value |
| pad_oe | output | LINES | Pad output enable, active high |

## Verification
The hardest situation to reach from the ports is the blink timing. The phase divider runs freely from reset, and software cannot see it or align to it. The bench therefore builds the divider with a short half-period. It watches pad_out over a window that spans many half-periods and counts the transitions there, which does not depend on the phase at the start. In every sampled cycle it also checks that the two blinking lines agree and that a static neighbour holds its level. Input-path checks wait out the synchroniser delay before reading, with the polarity mask set to mixed values.

// File: rtl/gpio_blink_pkg.sv
package gpio_blink_pkg;

    localparam int REG_W = 32;

    // Byte offsets of the register bank
    localparam int OFS_DOUT  = 'h00;
    localparam int OFS_DIR   = 'h04;
    localparam int OFS_BLINK = 'h08;
    localparam int OFS_POL   = 'h0C;
    localparam int OFS_DIN   = 'h10;

    typedef enum logic [2:0] {
        SEL_DOUT,
        SEL_DIR,
        SEL_BLINK,
        SEL_POL,
        SEL_DIN,
        SEL_NONE
    } reg_sel_e;

    typedef struct packed {
        logic [REG_W-1:0] dout;
        logic [REG_W-1:0] dir;
        logic [REG_W-1:0] blink;
        logic [REG_W-1:0] pol;
        logic [REG_W-1:0] rdata;
    } bank_regs_t;

    function automatic logic [REG_W-1:0] line_mask(input int lines);
        logic [63:0] wide;
        wide = (64'd1 << lines) - 64'd1;
        return wide[REG_W-1:0];
    endfunction

endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
    parameter int LINES = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw_in,
    output logic [LINES-1:0] sync_out
);
    typedef struct packed {
        logic [LINES-1:0] meta;
        logic [LINES-1:0] stable;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.meta   = raw_in;
        st_d.stable = st_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_out = st_q.stable;

    // R4: the stable stage lags the first stage by exactly one clock
    a_r4_sync_chain: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> st_q.stable == $past(st_q.meta));

endmodule

// File: rtl/gpio_blink_div.sv
module gpio_blink_div #(
    parameter int BLINK_HALF = 12_500_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic phase
);
    localparam int CNT_W = (BLINK_HALF < 2) ? 1 : $clog2(BLINK_HALF);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BLINK_HALF - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             phase;
    } div_t;

    div_t dv_d, dv_q;

    always_comb begin
        dv_d = dv_q;
        if (dv_q.cnt == CNT_LAST) begin
            dv_d.cnt   = '0;
            dv_d.phase = ~dv_q.phase;
        end else begin
            dv_d.cnt   = dv_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dv_q <= '0;
        else        dv_q <= dv_d;
    end

    assign phase = dv_q.phase;

    // R5: the phase only moves at the end of a half period
    a_r5_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (dv_q.cnt != CNT_LAST) |=> $stable(phase));

    a_r5_phase_flip: assert property (@(posedge clk) disable iff (!rst_n)
        (dv_q.cnt == CNT_LAST) |=> (phase != $past(phase)));

    // R5: counter never leaves its range
    a_r5_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        dv_q.cnt <= CNT_LAST);

endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_blink_pkg::*;
#(
    parameter int LINES  = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    input  logic [LINES-1:0]  din_sync,
    output logic [REG_W-1:0]  rdata,
    output logic [LINES-1:0]  dout,
    output logic [LINES-1:0]  dir,
    output logic [LINES-1:0]  blink
);
    localparam logic [REG_W-1:0] LMASK = line_mask(LINES);

    bank_regs_t rg_d, rg_q;
    reg_sel_e   sel;
    logic [REG_W-1:0] din_ext;
    logic [REG_W-1:0] wval;

    always_comb begin
        if      (addr == ADDR_W'(OFS_DOUT))  sel = SEL_DOUT;
        else if (addr == ADDR_W'(OFS_DIR))   sel = SEL_DIR;
        else if (addr == ADDR_W'(OFS_BLINK)) sel = SEL_BLINK;
        else if (addr == ADDR_W'(OFS_POL))   sel = SEL_POL;
        else if (addr == ADDR_W'(OFS_DIN))   sel = SEL_DIN;
        else                                 sel = SEL_NONE;
    end

    always_comb begin
        din_ext            = '0;
        din_ext[LINES-1:0] = din_sync;
    end

    assign wval = wdata & LMASK;

    always_comb begin
        rg_d       = rg_q;
        rg_d.rdata = '0;
        if (wr_en) begin
            case (sel)
                SEL_DOUT:  rg_d.dout  = wval;
                SEL_DIR:   rg_d.dir   = wval;
                SEL_BLINK: rg_d.blink = wval;
                SEL_POL:   rg_d.pol   = wval;
                default:   ;
            endcase
        end
        if (rd_en) begin
            case (sel)
                SEL_DOUT:  rg_d.rdata = rg_q.dout;
                SEL_DIR:   rg_d.rdata = rg_q.dir;
                SEL_BLINK: rg_d.rdata = rg_q.blink;
                SEL_POL:   rg_d.rdata = rg_q.pol;
                SEL_DIN:   rg_d.rdata = (din_ext ^ rg_q.pol) & LMASK;
                default:   rg_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rg_q       <= '0;
            rg_q.dir   <= LMASK;
        end else begin
            rg_q       <= rg_d;
        end
    end

    assign rdata = rg_q.rdata;
    assign dout  = rg_q.dout[LINES-1:0];
    assign dir   = rg_q.dir[LINES-1:0];
    assign blink = rg_q.blink[LINES-1:0];

    // R10: a write to a storage register lands masked
    a_r10_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(OFS_DIR)) |=> rg_q.dir == ($past(wdata) & LMASK));

    // R6, R7: writes to data-in or unmapped offsets leave all storage unchanged
    a_r6_r7_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (sel == SEL_DIN || sel == SEL_NONE))
        |=> ($stable(rg_q.dout) && $stable(rg_q.dir) && $stable(rg_q.blink) && $stable(rg_q.pol)));

    // R7: unmapped reads give zero
    a_r7_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sel == SEL_NONE) |=> rdata == '0);

    // R8: upper bits never appear on the read bus
    a_r8_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata & ~LMASK) == '0);

    // R9: no read, no data
    a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> rdata == '0);

endmodule

// File: rtl/gpio_blink_port.sv
module gpio_blink_port
    import gpio_blink_pkg::*;
#(
    parameter int LINES      = 32,
    parameter int ADDR_W     = 8,
    parameter int BLINK_HALF = 12_500_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic [LINES-1:0]  pin_in,
    output logic [LINES-1:0]  pad_out,
    output logic [LINES-1:0]  pad_oe
);
    logic [LINES-1:0] din_sync;
    logic [LINES-1:0] dout;
    logic [LINES-1:0] dir;
    logic [LINES-1:0] blink;
    logic             phase;

    gpio_sync2 #(.LINES(LINES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_in   (pin_in),
        .sync_out (din_sync)
    );

    gpio_blink_div #(.BLINK_HALF(BLINK_HALF)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .phase (phase)
    );

    gpio_regfile #(.LINES(LINES), .ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .addr     (addr),
        .wdata    (wdata),
        .din_sync (din_sync),
        .rdata    (rdata),
        .dout     (dout),
        .dir      (dir),
        .blink    (blink)
    );

    for (genvar i = 0; i < LINES; i++) begin : g_pad
        assign pad_out[i] = blink[i] ? phase : dout[i];
        assign pad_oe[i]  = ~dir[i];
    end

    // R2: a direction write of all ones releases every pad on the next cycle
    a_r2_all_inputs: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(OFS_DIR) && (&wdata[LINES-1:0])) |=> pad_oe == '0);

endmodule

// File: tb/gpio_blink_port_bench.sv
module gpio_blink_port_bench;

    localparam int LINES  = 12;
    localparam int ADDR_W = 8;
    localparam int HALF   = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic              rd_en = 1'b0;
    logic [ADDR_W-1:0] addr  = '0;
    logic [31:0]       wdata = '0;
    logic [31:0]       rdata;
    logic [LINES-1:0]  pin_in = '0;
    logic [LINES-1:0]  pad_out;
    logic [LINES-1:0]  pad_oe;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    gpio_blink_port #(.LINES(LINES), .ADDR_W(ADDR_W), .BLINK_HALF(HALF)) u_gpio_blink_port (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    // {offset, write value, expected read-back}
    localparam logic [71:0] VEC [7] = '{
        {8'h00, 32'hA5A5_A5A5, 32'h0000_05A5},   // R10 R8
        {8'h04, 32'h0000_F0F0, 32'h0000_00F0},   // R10 R2
        {8'h08, 32'h0000_0003, 32'h0000_0003},   // R10 R5
        {8'h0C, 32'hFFFF_0001, 32'h0000_0001},   // R10 R8
        {8'h08, 32'h0000_0000, 32'h0000_0000},   // R10
        {8'h14, 32'h1234_5678, 32'h0000_0000},   // R7
        {8'h02, 32'hFFFF_FFFF, 32'h0000_0000}    // R7 unaligned
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; addr = '0; wdata = '0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0; addr = '0;
        d = rdata;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        int toggles;
        logic prev;

        pin_in = 12'h3C0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1 reset state
        chk("R1 pad_oe", 32'(pad_oe), 32'h0);
        chk("R1 pad_out", 32'(pad_out), 32'h0);
        bus_rd(8'h04, v); chk("R1 dir", v, 32'h0000_0FFF);
        bus_rd(8'h00, v); chk("R1 dout", v, 32'h0);
        bus_rd(8'h0C, v); chk("R1 pol", v, 32'h0);
        bus_rd(8'h10, v); chk("R4 din no invert", v, 32'h0000_03C0);

        // table walk: write, read back
        for (int k = 0; k < 7; k++) begin
            bus_wr(VEC[k][71:64], VEC[k][63:32]);
            bus_rd(VEC[k][71:64], v);
            chk("R10 R7 R8 table", v, VEC[k][31:0]);
        end

        // R9: idle cycle gives zero
        @(negedge clk); chk("R9 idle rdata", rdata, 32'h0);

        // R2 / R3 pads
        chk("R2 pad_oe", 32'(pad_oe), 32'h0000_0F0F);
        chk("R3 pad_out", 32'(pad_out), 32'h0000_05A5);

        // R4 input path with polarity 0x001
        @(negedge clk); pin_in = 12'hABC;
        repeat (2) @(negedge clk);
        bus_rd(8'h10, v); chk("R4 din pol1", v, 32'h0000_0ABD);
        bus_wr(8'h0C, 32'h0000_0FFF);
        bus_rd(8'h10, v); chk("R4 din pol all", v, 32'h0000_0543);

        // R6 write to data-in is ignored
        bus_wr(8'h10, 32'hFFFF_FFFF);
        bus_rd(8'h10, v); chk("R6 din after write", v, 32'h0000_0543);
        bus_rd(8'h00, v); chk("R6 dout intact", v, 32'h0000_05A5);
        bus_rd(8'h04, v); chk("R6 dir intact", v, 32'h0000_00F0);
        bus_rd(8'h0C, v); chk("R6 pol intact", v, 32'h0000_0FFF);
        bus_rd(8'h08, v); chk("R6 blink intact", v, 32'h0);

        // R7 unmapped write left registers alone (table wrote 0x14 and 0x02)
        chk("R7 pads intact", 32'(pad_out), 32'h0000_05A5);

        // R5 blink on lines 0 and 1, static high on line 2
        bus_wr(8'h00, 32'h0000_0004);
        bus_wr(8'h08, 32'h0000_0003);
        @(negedge clk);
        prev = pad_out[0];
        toggles = 0;
        for (int c = 0; c < 10 * HALF; c++) begin
            @(negedge clk);
            if (pad_out[0] != prev) toggles++;
            prev = pad_out[0];
            if (pad_out[0] != pad_out[1]) begin
                fails++;
                $display("FAIL R5 lines differ actual=%b expected=%b", pad_out[1], pad_out[0]);
            end
            if (pad_out[2] != 1'b1) begin
                fails++;
                $display("FAIL R5 static line actual=%b expected=1", pad_out[2]);
            end
        end
        checks += 2;
        chk("R5 toggle count", 32'(toggles), 32'd10);

        // R5 blink off returns to static value
        bus_wr(8'h08, 32'h0);
        @(negedge clk);
        chk("R5 blink off", 32'(pad_out), 32'h0000_0004);

        // R1 reset again mid-run
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk("R1 reset oe", 32'(pad_oe), 32'h0);
        bus_rd(8'h00, v); chk("R1 reset dout", v, 32'h0);

        finish_run();
    end

endmodule